// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

This block is a register-mapped bank of independent 32-bit down-counting timers that share one interrupt line. A simple single-cycle write port and a combinational read port reach every register. Each channel has a control word, an interval (reload) register and a readable current count. The control word enables the channel, requests an immediate reload, picks one of two tick inputs, sets a power-of-two prescale and chooses between periodic and single-shot operation.

Software first writes the interval, then writes the control word with reload and enable set. Every selected tick that passes the prescaler moves the count down by one. A step that lands on a count of zero marks the channel's pending bit. The channel then reloads or stops, depending on its mode. One shared enable register and one write-one-to-clear pending register cover all channels. The interrupt output is high while any channel is both pending and enabled.

Top module: `cdt_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register reads 0 and irq is low.
- R2: The interrupt-enable register is at offset 0x00 and the pending register at 0x04, with bit n belonging to channel n. The bank of channel n starts at 0x10 + 0x10·n: control at +0x0, interval at +0x4 and current count at +0x8. The interval reads back as written, and addresses outside this map read 0.
- R3: The control word uses these bits: 0 is enable, 1 is reload, 3:2 is the tick source, 6:4 is the prescale and 7 is the mode. The reload bit always reads back as 0.
- R4: A control write with bit 1 set copies the interval into the current count. The new count is readable from the next cycle, whether or not the channel is enabled.
- R5: Source code 1 counts pulses on tick_ref and code 2 counts pulses on tick_fast. Codes 0 and 3 count nothing, and the unselected tick input has no effect.
- R6: With prescale p, the count moves once per 2^p selected ticks (p = 0..7). The divider restarts on any control write and while the channel is disabled.
- R7: Each step lowers a nonzero count by one. After reload from an interval of 0xFFFFFFFF, one step gives 0xFFFFFFFE.
- R8: A step that arrives while the count is 0 sets the channel's pending bit, so one period spans interval+1 steps.
- R9: In mode 0 (periodic), an expiring step reloads the count from the interval and the channel keeps running.
- R10: In mode 1 (single-shot), an expiring step clears the enable bit. The count stays at 0, and no further steps or pending bits follow.
- R11: Writing the pending register clears each bit written as 1 and keeps each bit written as 0. An expiry in the same cycle as a clear leaves its bit set.
- R12: irq is high exactly when some channel has both its pending and enable bits set. A pending bit sets even while its enable bit is 0.
- R13: A channel whose enable bit is 0 holds its count regardless of the tick inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| tick_ref | input | 1 | Reference tick, one pulse per cycle high |
| tick_fast | input | 1 | Alternate faster tick |
| irq | output | 1 | Combined interrupt |

## Verification
A divider that has drifted out of step shows up as a count that moves one tick early or late. The bench exposes this at the current-count register within one prescale window, because it reads every register after every tick pulse and compares against an arithmetic model. A lost or stray expiry appears in the pending register and on irq in the cycle right after the step that caused it. A wrong one-shot stop appears on the following step as a count that reloads or keeps moving.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the timer bank.
// Assumes byte offsets within a channel slot of 16 bytes.
package cdt_pkg;
    localparam logic [7:0] OFF_IEN   = 8'h00;
    localparam logic [7:0] OFF_PEND  = 8'h04;
    localparam logic [3:0] SUB_CTRL  = 4'h0;
    localparam logic [3:0] SUB_IVAL  = 4'h4;
    localparam logic [3:0] SUB_CUR   = 4'h8;

    localparam int CB_EN     = 0;
    localparam int CB_RELOAD = 1;
    localparam int CB_SRC_LO = 2;
    localparam int CB_PS_LO  = 4;
    localparam int CB_MODE   = 7;

    localparam logic [1:0] SRC_REF  = 2'd1;
    localparam logic [1:0] SRC_FAST = 2'd2;

    typedef struct packed {
        logic       mode;
        logic [2:0] ps;
        logic [1:0] src;
        logic       en;
    } ctrl_t;

    // Packs a stored control word into its readable layout (reload reads 0).
    function automatic logic [7:0] ctrl_word(input ctrl_t c);
        logic [7:0] w;
        w = '0;
        w[CB_EN] = c.en;
        w[CB_SRC_LO +: 2] = c.src;
        w[CB_PS_LO +: 3] = c.ps;
        w[CB_MODE] = c.mode;
        return w;
    endfunction
endpackage

// File: rtl/cdt_prescale.sv
`timescale 1ns/1ps
// Power-of-two tick divider: emits one step per 2^ps input ticks.
// Assumes tick_in is a one-cycle pulse; clear restarts the count.
module cdt_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            tick_in,
    input  logic [PS_W-1:0] ps,
    output logic            step
);
    localparam int CNT_W = (1 << PS_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Terminal count of the divider for the current prescale.
    assign limit = ~({CNT_W{1'b1}} << ps);
    assign step  = tick_in && (cnt == limit);

    // Counts selected ticks and wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (tick_in) begin
            cnt <= step ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cdt_channel.sv
`timescale 1ns/1ps
// One down-counting channel: control, interval and current count.
// Assumes a control write takes priority over a step in the same cycle.
module cdt_channel
    import cdt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          ival_wr,
    input  logic [DW-1:0] wdata,
    input  logic          tick_ref,
    input  logic          tick_fast,
    output ctrl_t         ctrl,
    output logic [DW-1:0] ival,
    output logic [DW-1:0] cur,
    output logic          expire
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] ival_q;
    logic [DW-1:0] cur_q;
    logic          tick_sel;
    logic          step;

    // Picks the tick input named by the source field.
    always_comb begin
        case (ctrl_q.src)
            SRC_REF:  tick_sel = tick_ref;
            SRC_FAST: tick_sel = tick_fast;
            default:  tick_sel = 1'b0;
        endcase
    end

    cdt_prescale #(.PS_W(3)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ctrl_wr || !ctrl_q.en),
        .tick_in(tick_sel),
        .ps     (ctrl_q.ps),
        .step   (step)
    );

    assign expire = step && ctrl_q.en && !ctrl_wr && (cur_q == '0);

    // Control word storage; single-shot expiry drops enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.en   <= wdata[CB_EN];
            ctrl_q.src  <= wdata[CB_SRC_LO +: 2];
            ctrl_q.ps   <= wdata[CB_PS_LO +: 3];
            ctrl_q.mode <= wdata[CB_MODE];
        end else if (expire && ctrl_q.mode) begin
            ctrl_q.en <= 1'b0;
        end
    end

    // Interval register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q <= '0;
        end else if (ival_wr) begin
            ival_q <= wdata;
        end
    end

    // Current count: reload on request, else step down or reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (ctrl_wr) begin
            if (wdata[CB_RELOAD]) cur_q <= ival_q;
        end else if (ctrl_q.en && step) begin
            if (cur_q != '0)       cur_q <= cur_q - 1'b1;
            else if (!ctrl_q.mode) cur_q <= ival_q;
        end
    end

    assign ctrl = ctrl_q;
    assign ival = ival_q;
    assign cur  = cur_q;
endmodule

// File: rtl/cdt_irq.sv
`timescale 1ns/1ps
// Shared interrupt enable and write-one-to-clear pending registers.
// Assumes an expiry in the same cycle as a clear wins.
module cdt_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ien_wr,
    input  logic         pend_wr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] expire,
    output logic [N-1:0] ien,
    output logic [N-1:0] pend,
    output logic         irq
);
    logic [N-1:0] ien_q;
    logic [N-1:0] pend_q;
    logic [N-1:0] clr;

    assign clr = pend_wr ? wdata : '0;

    // Interrupt enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= wdata;
    end

    // Pending bits: set by expiry, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | expire;
    end

    assign ien  = ien_q;
    assign pend = pend_q;
    assign irq  = |(pend_q & ien_q);
endmodule

// File: rtl/cdt_bank.sv
`timescale 1ns/1ps
// Top of the timer bank: address decode, read mux and channel array.
// Assumes NUM_CH < 2^(AW-4) - 1 so every bank fits in the address space.
module cdt_bank
    import cdt_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DW     = 32,
    parameter int AW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tick_ref,
    input  logic          tick_fast,
    output logic          irq
);
    localparam int SLOT_W = AW - 4;

    logic [SLOT_W-1:0] slot;
    logic [3:0]        sub;
    ctrl_t             ctrl_a [NUM_CH];
    logic [DW-1:0]     ival_a [NUM_CH];
    logic [DW-1:0]     cur_a  [NUM_CH];
    logic [NUM_CH-1:0] expire_v;
    logic [NUM_CH-1:0] run_v;
    logic [NUM_CH-1:0] mode_v;
    logic [NUM_CH-1:0] ien_v;
    logic [NUM_CH-1:0] pend_v;

    assign slot = bus_addr[AW-1:4];
    assign sub  = bus_addr[3:0];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic hit;
        assign hit = (slot == SLOT_W'(ch + 1));

        cdt_channel #(.DW(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctrl_wr  (bus_wr && hit && (sub == SUB_CTRL)),
            .ival_wr  (bus_wr && hit && (sub == SUB_IVAL)),
            .wdata    (bus_wdata),
            .tick_ref (tick_ref),
            .tick_fast(tick_fast),
            .ctrl     (ctrl_a[ch]),
            .ival     (ival_a[ch]),
            .cur      (cur_a[ch]),
            .expire   (expire_v[ch])
        );

        assign run_v[ch]  = ctrl_a[ch].en;
        assign mode_v[ch] = ctrl_a[ch].mode;
    end

    cdt_irq #(.N(NUM_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ien_wr (bus_wr && (bus_addr == AW'(OFF_IEN))),
        .pend_wr(bus_wr && (bus_addr == AW'(OFF_PEND))),
        .wdata  (bus_wdata[NUM_CH-1:0]),
        .expire (expire_v),
        .ien    (ien_v),
        .pend   (pend_v),
        .irq    (irq)
    );

    // Read mux over shared registers and all channel banks.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_IEN))  bus_rdata = DW'(ien_v);
        if (bus_addr == AW'(OFF_PEND)) bus_rdata = DW'(pend_v);
        for (int c = 0; c < NUM_CH; c++) begin
            if (slot == SLOT_W'(c + 1)) begin
                case (sub)
                    SUB_CTRL: bus_rdata = DW'(ctrl_word(ctrl_a[c]));
                    SUB_IVAL: bus_rdata = ival_a[c];
                    SUB_CUR:  bus_rdata = cur_a[c];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cdt_bank_chk.sv
`timescale 1ns/1ps
// Property checker for cdt_bank, attached by bind below.
// Assumes it observes the internal expiry, run, mode and register vectors.
module cdt_bank_chk #(
    parameter int NUM_CH = 3,
    parameter int AW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [NUM_CH-1:0] low_wdata,
    input logic              irq,
    input logic [NUM_CH-1:0] expire_v,
    input logic [NUM_CH-1:0] run_v,
    input logic [NUM_CH-1:0] mode_v,
    input logic [NUM_CH-1:0] pend_v
);
    AST_PEND_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire_v) |=> ((pend_v & $past(expire_v)) == $past(expire_v))); // R8

    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(8'h04))
        |=> ((pend_v & $past(low_wdata) & ~$past(expire_v)) == '0)); // R11

    AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(expire_v & mode_v)) |=> ((run_v & $past(expire_v & mode_v)) == '0)); // R10

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|expire_v) || $past(bus_wr && bus_addr == AW'(8'h00)))); // R12
endmodule

bind cdt_bank cdt_bank_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .low_wdata(bus_wdata[NUM_CH-1:0]),
    .irq      (irq),
    .expire_v (expire_v),
    .run_v    (run_v),
    .mode_v   (mode_v),
    .pend_v   (pend_v)
);

// File: tb/cdt_bank_test.sv
`timescale 1ns/1ps
// Self-checking bench for cdt_bank with an arithmetic register model.
module cdt_bank_test;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_ref = 1'b0;
    logic        tick_fast = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;

    logic [31:0] m_cur [NCH];
    logic [31:0] m_iv  [NCH];
    logic        m_en  [NCH];
    logic        m_mode[NCH];
    logic [1:0]  m_src [NCH];
    logic [2:0]  m_ps  [NCH];
    int          m_pc  [NCH];
    logic [NCH-1:0] m_pend;
    logic [NCH-1:0] m_ien;

    always #4 clk = ~clk;

    cdt_bank #(.NUM_CH(NCH), .DW(32), .AW(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_ref(tick_ref),
        .tick_fast(tick_fast), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_cur[c] = '0; m_iv[c] = '0; m_en[c] = 1'b0; m_mode[c] = 1'b0;
            m_src[c] = '0; m_ps[c] = '0; m_pc[c] = 0;
        end
        m_pend = '0; m_ien = '0;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        int c;
        if (a == 8'h00) m_ien = d[NCH-1:0];
        else if (a == 8'h04) m_pend = m_pend & ~d[NCH-1:0];
        else if (a >= 8'h10 && a < 8'h10 + 8'(16 * NCH)) begin
            c = int'(a[7:4]) - 1;
            if (a[3:0] == 4'h4) m_iv[c] = d;
            else if (a[3:0] == 4'h0) begin
                m_en[c] = d[0]; m_src[c] = d[3:2]; m_ps[c] = d[6:4];
                m_mode[c] = d[7]; m_pc[c] = 0;
                if (d[1]) m_cur[c] = m_iv[c];
            end
        end
    endtask

    task automatic model_tick(input logic r, input logic f);
        logic sel;
        for (int c = 0; c < NCH; c++) begin
            sel = (m_src[c] == 2'd1) ? r : (m_src[c] == 2'd2) ? f : 1'b0;
            if (m_en[c] && sel) begin
                if (m_pc[c] == (1 << m_ps[c]) - 1) begin
                    m_pc[c] = 0;
                    if (m_cur[c] == 0) begin
                        m_pend[c] = 1'b1;
                        if (m_mode[c]) m_en[c] = 1'b0;
                        else m_cur[c] = m_iv[c];
                    end else begin
                        m_cur[c] = m_cur[c] - 1;
                    end
                end else begin
                    m_pc[c]++;
                end
            end
            if (!m_en[c]) m_pc[c] = 0;
        end
    endtask

    // One bus write and/or tick pulse in a single cycle.
    task automatic cycle(input logic w, input logic [7:0] a, input logic [31:0] d,
                         input logic r, input logic f);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; tick_ref = r; tick_fast = f;
        @(posedge clk);
        if (w) model_write(a, d);
        model_tick(r, f);
        @(negedge clk);
        bus_wr = 1'b0; tick_ref = 1'b0; tick_fast = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic pulse(input logic r, input logic f);
        cycle(1'b0, 8'h00, 32'h0, r, f);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] v;
        rd(8'h00, v); check({req, " ien"}, v, 32'(m_ien));
        rd(8'h04, v); check({req, " pend"}, v, 32'(m_pend));
        for (int c = 0; c < NCH; c++) begin
            rd(8'(16 * c + 16), v);
            check({req, " ctrl"}, v, {24'h0, m_mode[c], m_ps[c], m_src[c], 1'b0, m_en[c]});
            rd(8'(16 * c + 20), v); check({req, " ival"}, v, m_iv[c]);
            rd(8'(16 * c + 24), v); check({req, " cur"}, v, m_cur[c]);
        end
        check({req, " irq"}, 32'(irq), 32'(|(m_pend & m_ien)));
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R2: map and readback of intervals; unmapped holes read 0
        wr(8'h14, 32'h1234_5678);
        wr(8'h24, 32'hCAFE_0001);
        wr(8'h34, 32'h0000_00FF);
        check_all("R2 map");
        rd(8'h0C, v); check("R2 hole", v, 32'h0);
        rd(8'h44, v); check("R2 beyond", v, 32'h0);
        rd(8'h1C, v); check("R2 slot gap", v, 32'h0);

        // R3 R4: field packing, reload self-clear, reload while disabled
        wr(8'h20, 32'h0000_00DA);
        check_all("R3 R4 fields");
        rd(8'h28, v); check("R4 reload copy", v, 32'hCAFE_0001);

        // R13: disabled channels hold under ticks
        for (int i = 0; i < 6; i++) pulse(1'b1, 1'b1);
        check_all("R13 idle");
        wr(8'h20, 32'h0);
        wr(8'h30, 32'h0);

        // R6 R7 R8 R9: sweep source and prescale on channel 0
        for (int s = 1; s <= 2; s++) begin
            for (int p = 0; p < 4; p++) begin
                wr(8'h14, 32'd4);
                wr(8'h10, 32'h3 | (32'(s) << 2) | (32'(p) << 4));
                for (int i = 0; i < 26; i++) begin
                    pulse(1'((i % 3) != 0), 1'((i % 2) == 0));
                    check_all("R5 R6 R7 R8 R9 sweep");
                end
                wr(8'h04, 32'h7);
            end
        end

        // R5: source codes 0 and 3 count nothing
        wr(8'h14, 32'd9);
        wr(8'h10, 32'h3);
        for (int i = 0; i < 4; i++) pulse(1'b1, 1'b1);
        check_all("R5 src0");
        wr(8'h10, 32'h0D);
        for (int i = 0; i < 4; i++) pulse(1'b1, 1'b1);
        check_all("R5 src3");

        // R6: largest prescale, 128 ticks per step
        wr(8'h10, 32'h77);
        for (int i = 0; i < 130; i++) pulse(1'b1, 1'b0);
        check_all("R6 div128");
        rd(8'h18, v); check("R6 one step", v, 32'd8);

        // R7: full 32-bit range
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h10, 32'h07);
        pulse(1'b1, 1'b0);
        rd(8'h18, v); check("R7 full range", v, 32'hFFFF_FFFE);
        wr(8'h10, 32'h0);

        // R10: single shot stops and stays at zero
        wr(8'h04, 32'h7);
        wr(8'h24, 32'd2);
        wr(8'h20, 32'h87);
        for (int i = 0; i < 6; i++) begin
            pulse(1'b1, 1'b0);
            check_all("R10 oneshot");
        end
        wr(8'h04, 32'h7);
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        check_all("R10 no repeat");

        // R12: pending without enable, then irq follows enable
        wr(8'h34, 32'd0);
        wr(8'h30, 32'h0B);
        pulse(1'b0, 1'b1);
        wr(8'h30, 32'h0);
        check_all("R12 masked");
        check("R12 irq low", 32'(irq), 32'h0);
        wr(8'h00, 32'h4);
        check_all("R12 unmasked");
        check("R12 irq high", 32'(irq), 32'h1);

        // R11: writing zero keeps, writing the read value clears
        wr(8'h04, 32'h0);
        check_all("R11 keep");
        rd(8'h04, v);
        wr(8'h04, v);
        check_all("R11 clear");

        // R11: set wins over clear in the same cycle
        wr(8'h14, 32'd0);
        wr(8'h10, 32'h07);
        pulse(1'b1, 1'b0);
        cycle(1'b1, 8'h04, 32'h7, 1'b1, 1'b0);
        check_all("R11 collide");
        rd(8'h04, v); check("R11 set wins", v, 32'h1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule